// File: doc/BRIEF.md
# Multiframe-Aligned Repeating Message Transmitter

This block feeds the unformatted transmit data link of a framer. A processor loads a message of 1 to `DEPTH` bytes through a byte write port and then pulses a commit strobe that carries the message length. In repeat mode the block replays that message without end. Each replay starts on the bit request that comes with a multiframe-start pulse from the transmit timebase. A message that ends before the next boundary is followed by idle ones until that boundary.

Storage is split into two banks. Written bytes always go to the bank that is not playing. A commit only marks that bank as pending. The banks swap at the first multiframe start after the playing message has completed, so a message in flight is never cut short. The caller keeps consecutive messages continuous by choosing lengths that are whole multiples of the data link bits in one multiframe. With a 24-frame T1 multiframe that holds in both superframe and extended-superframe operation, so a superframe message covers two 12-frame superframes.

When repeat mode is off, the same storage works as a plain byte FIFO of 2×`DEPTH` entries that drains one bit per request with no alignment. Changing the mode flushes everything. Bits leave least significant first. The serial output is meaningful in the cycles where the bit request is high.

Top module: `dl_rpt_tx`

## Requirements
- R1: After reset no message is held, and `tx_bit` is 1 on every bit request until a message is committed.
- R2: In repeat mode a committed message starts on the first bit request that comes with `mf_start`, and its bytes go out in write order, least significant bit first.
- R3: When a message completes, it restarts on the next bit request that comes with `mf_start`. Between its end and that boundary, `tx_bit` is 1.
- R4: An `mf_start` that arrives while a message is still playing is ignored, and the message continues without a break.
- R5: A message committed while another is playing begins only at the first multiframe start after the playing message completes.
- R6: A commit whose length is 0 or greater than `DEPTH` is ignored. The message that is playing or pending is left unchanged.
- R7: After a commit, only the first `DEPTH` bytes written are stored. Later writes do not overwrite them.
- R8: With repeat mode off, written bytes leave in write order, LSB first, one bit per request, with no alignment. `commit` and `mf_start` have no effect, and an empty FIFO sends 1.
- R9: The FIFO holds 2×`DEPTH` bytes. A write to a full FIFO is dropped.
- R10: A change of `repeat_en` discards all stored and pending data, so the output idles at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| repeat_en | input | 1 | 1 = repeat mode (double-buffered), 0 = plain FIFO |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to store |
| commit | input | 1 | Makes the written message pending (repeat mode) |
| commit_len | input | $clog2(DEPTH+1) | Length in bytes given with `commit` |
| mf_start | input | 1 | Multiframe start, qualified by `bit_req` |
| bit_req | input | 1 | Timebase requests one data link bit this cycle |
| tx_bit | output | 1 | Serial data link bit, valid when `bit_req` is high |

## Verification
On every cycle the assertions check the following:
- bank swaps and playback starts fall only on a requested multiframe start;
- an active length stays within 1..`DEPTH`;
- the write count and FIFO fill never exceed their capacities;
- only one source drives the output;
- a mode change leaves nothing driving on the following cycle.

Only the bench scenarios can show the actual bit order, the content of each replay, idle fill before a boundary, and the deferral of a new message behind one that spans boundaries. The same holds for dropped overflow writes and FIFO ordering, which are visible only by comparing whole bit streams.

// File: rtl/dl_rpt_pkg.sv
// Shared types and helpers for the repeating data link transmitter.
// Assumes nothing beyond byte-wide message storage.
package dl_rpt_pkg;
    typedef logic [7:0] dl_byte_t;

    // True when a commit length names a usable message.
    function automatic logic len_ok(input int len, input int depth);
        return (len >= 1) && (len <= depth);
    endfunction
endpackage

// File: rtl/dl_msg_store.sv
// Byte storage shared by the repeat and FIFO controllers.
// One write port, asynchronous read. Contents are not reset: no reader
// touches an entry before it has been written.
module dl_msg_store
    import dl_rpt_pkg::*;
#(
    parameter int ADDR_W = 7,
    localparam int ENTRIES = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  dl_byte_t          wdata,
    input  logic [ADDR_W-1:0] raddr,
    output dl_byte_t          rdata
);
    dl_byte_t mem [ENTRIES];

    // Store one byte per write strobe.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Present the addressed byte without delay.
    assign rdata = mem[raddr];
endmodule

// File: rtl/dl_rpt_ctrl.sv
// Repeat-mode controller. Holds an active bank and a pending bank.
// Writes fill the non-active bank, and a valid commit marks it pending.
// At a multiframe start with nothing playing, the pending bank (if any)
// becomes active and playback starts at byte 0, bit 0. Playback ends
// after the last bit of the last byte and waits for the next boundary.
// Assumes mf_start is meaningful only together with bit_req.
module dl_rpt_ctrl
    import dl_rpt_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int LEN_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH),
    localparam int ADDR_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              flush,
    input  logic              wr_en,
    input  logic              commit,
    input  logic [LEN_W-1:0]  commit_len,
    input  logic              mf_start,
    input  logic              bit_req,
    output logic              wr_we,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [2:0]        rd_bit,
    output logic              drive
);
    logic             act_bank, act_vld, pend_vld, playing;
    logic [LEN_W-1:0] act_len, pend_len, wr_cnt, cur_len;
    logic [IDX_W-1:0] byte_idx, rd_byte;
    logic [2:0]       bit_idx;
    logic             commit_ok, pend_use, start_now, swap_now, cur_bank, last_bit;

    // Decide whether this request starts a message and from which bank.
    always_comb begin
        commit_ok = en && commit && len_ok(int'(commit_len), DEPTH);
        pend_use  = pend_vld && !commit_ok;
        start_now = en && bit_req && mf_start && !playing && (pend_use || act_vld);
        swap_now  = start_now && pend_use;
        cur_bank  = swap_now ? ~act_bank : act_bank;
        cur_len   = swap_now ? pend_len : act_len;
        rd_byte   = start_now ? '0 : byte_idx;
        rd_bit    = start_now ? 3'd0 : bit_idx;
        drive     = start_now || (en && playing);
        last_bit  = (rd_bit == 3'd7) && (LEN_W'(rd_byte) == cur_len - LEN_W'(1));
        wr_we     = en && wr_en && (wr_cnt < LEN_W'(DEPTH));
        wr_addr   = {~act_bank, wr_cnt[IDX_W-1:0]};
        rd_addr   = {cur_bank, rd_byte};
    end

    // Track banks, the pending message and the playback position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_bank <= 1'b0; act_vld <= 1'b0; pend_vld <= 1'b0; playing <= 1'b0;
            act_len  <= '0;   pend_len <= '0;  wr_cnt   <= '0;
            byte_idx <= '0;   bit_idx  <= '0;
        end else if (flush) begin
            act_vld <= 1'b0; pend_vld <= 1'b0; playing <= 1'b0;
            wr_cnt  <= '0;   byte_idx <= '0;   bit_idx <= '0;
        end else begin
            if (wr_we) wr_cnt <= wr_cnt + LEN_W'(1);
            if (commit_ok) begin
                pend_vld <= 1'b1;
                pend_len <= commit_len;
                wr_cnt   <= '0;
            end else if (swap_now) begin
                pend_vld <= 1'b0;
            end
            if (swap_now) begin
                act_bank <= ~act_bank;
                act_len  <= pend_len;
                act_vld  <= 1'b1;
            end
            if (drive && bit_req) begin
                if (last_bit) begin
                    playing  <= 1'b0;
                    byte_idx <= '0;
                    bit_idx  <= '0;
                end else begin
                    playing <= 1'b1;
                    if (rd_bit == 3'd7) begin
                        bit_idx  <= '0;
                        byte_idx <= rd_byte + IDX_W'(1);
                    end else begin
                        bit_idx  <= rd_bit + 3'd1;
                        byte_idx <= rd_byte;
                    end
                end
            end
        end
    end

    AST_SWAP_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_bank) |-> $past(bit_req && mf_start && !playing)); // R5
    AST_START_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(playing) |-> $past(bit_req && mf_start)); // R2
    AST_ACTIVE_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        act_vld |-> (act_len >= LEN_W'(1) && act_len <= LEN_W'(DEPTH))); // R6
    AST_WRITE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt <= LEN_W'(DEPTH)); // R7
endmodule

// File: rtl/dl_fifo_ctrl.sv
// Plain-FIFO controller used when repeat mode is off. Fill pointers run
// over the whole shared storage. The head byte is sent LSB first, one bit
// per request, and is popped after its eighth bit. Assumes the shared
// storage has 2**ADDR_W entries.
module dl_fifo_ctrl #(
    parameter int ADDR_W = 7,
    localparam int FDEPTH = 1 << ADDR_W,
    localparam int CNT_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              flush,
    input  logic              wr_en,
    input  logic              bit_req,
    output logic              wr_we,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [2:0]        rd_bit,
    output logic              drive
);
    logic [ADDR_W-1:0] head, tail;
    logic [CNT_W-1:0]  count;
    logic [2:0]        bit_idx;
    logic              pop;

    // Derive push and pop from the fill level and requests.
    always_comb begin
        wr_we   = en && wr_en && (count < CNT_W'(FDEPTH));
        drive   = en && (count != '0);
        pop     = drive && bit_req && (bit_idx == 3'd7);
        wr_addr = tail;
        rd_addr = head;
        rd_bit  = bit_idx;
    end

    // Move pointers, fill level and bit position.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            head <= '0; tail <= '0; count <= '0; bit_idx <= '0;
        end else begin
            if (wr_we) tail <= tail + ADDR_W'(1);
            if (pop)   head <= head + ADDR_W'(1);
            if (wr_we && !pop)      count <= count + CNT_W'(1);
            else if (pop && !wr_we) count <= count - CNT_W'(1);
            if (drive && bit_req) bit_idx <= bit_idx + 3'd1;
        end
    end

    AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(FDEPTH)); // R9
    AST_FIFO_EMPTY_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> (head == tail)); // R8
endmodule

// File: rtl/dl_rpt_tx.sv
// Top of the repeating data link transmitter. Picks the repeat controller
// or the FIFO controller from repeat_en, flushes both when the mode changes,
// and shares one byte store between them. tx_bit is 1 whenever no
// controller is driving. Assumes tx_bit is sampled only when bit_req is high.
module dl_rpt_tx
    import dl_rpt_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int LEN_W = $clog2(DEPTH + 1),
    localparam int ADDR_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             repeat_en,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             commit,
    input  logic [LEN_W-1:0] commit_len,
    input  logic             mf_start,
    input  logic             bit_req,
    output logic             tx_bit
);
    logic              mode_q, mode_chg;
    logic              r_we, f_we, r_drive, f_drive;
    logic [ADDR_W-1:0] r_waddr, f_waddr, r_raddr, f_raddr;
    logic [2:0]        r_bit, f_bit;
    dl_byte_t          rd_data;

    // Remember the mode so that a change can flush the controllers.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= 1'b0;
        else        mode_q <= repeat_en;
    end
    assign mode_chg = (repeat_en != mode_q);

    dl_rpt_ctrl #(.DEPTH(DEPTH)) rpt_i (
        .clk(clk), .rst_n(rst_n), .en(repeat_en && !mode_chg), .flush(mode_chg),
        .wr_en(wr_en), .commit(commit), .commit_len(commit_len),
        .mf_start(mf_start), .bit_req(bit_req),
        .wr_we(r_we), .wr_addr(r_waddr), .rd_addr(r_raddr), .rd_bit(r_bit), .drive(r_drive)
    );

    dl_fifo_ctrl #(.ADDR_W(ADDR_W)) fifo_i (
        .clk(clk), .rst_n(rst_n), .en(!repeat_en && !mode_chg), .flush(mode_chg),
        .wr_en(wr_en), .bit_req(bit_req),
        .wr_we(f_we), .wr_addr(f_waddr), .rd_addr(f_raddr), .rd_bit(f_bit), .drive(f_drive)
    );

    dl_msg_store #(.ADDR_W(ADDR_W)) store_i (
        .clk(clk), .we(r_we || f_we), .waddr(repeat_en ? r_waddr : f_waddr),
        .wdata(wr_data), .raddr(r_drive ? r_raddr : f_raddr), .rdata(rd_data)
    );

    // Send the selected data bit, or idle ones.
    always_comb begin
        if (r_drive)      tx_bit = rd_data[r_bit];
        else if (f_drive) tx_bit = rd_data[f_bit];
        else              tx_bit = 1'b1;
    end

    AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !(r_drive && f_drive)); // R8
    AST_FLUSH_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> !(r_drive || f_drive)); // R10
endmodule

// File: tb/dl_rpt_tx_tb.sv
module dl_rpt_tx_tb_top;
    localparam int DEPTH = 64;
    localparam int LEN_W = $clog2(DEPTH + 1);
    localparam int MFB = 16;

    logic clk = 1'b0, rst_n = 1'b0, repeat_en = 1'b1, wr_en = 1'b0;
    logic commit = 1'b0, mf_start = 1'b0, bit_req = 1'b0, tx_bit;
    logic [7:0] wr_data = '0;
    logic [LEN_W-1:0] commit_len = '0;
    int n_run = 0, n_fail = 0;
    bit done = 1'b0;
    logic  exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    dl_rpt_tx #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .repeat_en(repeat_en), .wr_en(wr_en), .wr_data(wr_data),
        .commit(commit), .commit_len(commit_len), .mf_start(mf_start), .bit_req(bit_req),
        .tx_bit(tx_bit)
    );

    task automatic exp_byte(input logic [7:0] b, input string tag);
        for (int i = 0; i < 8; i++) begin exp_q.push_back(b[i]); tag_q.push_back(tag); end
    endtask
    task automatic exp_ones(input int n, input string tag);
        for (int i = 0; i < n; i++) begin exp_q.push_back(1'b1); tag_q.push_back(tag); end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en = 0; commit = 0; bit_req = 0; mf_start = 0;
        end
    endtask
    task automatic wr_byte(input logic [7:0] b);
        @(negedge clk);
        wr_en = 1; wr_data = b; commit = 0; bit_req = 0; mf_start = 0;
        idle(1);
    endtask
    task automatic do_commit(input int len);
        @(negedge clk);
        wr_en = 0; commit = 1; commit_len = LEN_W'(len); bit_req = 0; mf_start = 0;
        idle(1);
    endtask
    // Aligned multiframes: mf_start with the first request of each.
    task automatic run_mf(input int n);
        for (int k = 0; k < n; k++)
            for (int b = 0; b < MFB; b++) begin
                @(negedge clk);
                wr_en = 0; commit = 0; bit_req = 1; mf_start = (b == 0);
                idle(1);
            end
    endtask
    // Unaligned requests, with mf_start and commit pulsed at bit 3.
    task automatic run_plain(input int n);
        for (int b = 0; b < n; b++) begin
            @(negedge clk);
            wr_en = 0; bit_req = 1; mf_start = (b == 3); commit = (b == 3); commit_len = 7'd1;
            idle(1);
        end
    endtask

    // Monitor: pop and compare one expected bit per request.
    initial forever begin
        @(negedge clk); #5;
        if (rst_n && bit_req) begin
            n_run++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R8 unexpected request: actual=%b expected=none", tx_bit);
            end else begin
                logic e;
                string t;
                e = exp_q.pop_front(); t = tag_q.pop_front();
                if (tx_bit !== e) begin
                    n_fail++;
                    $display("FAIL %s: actual=%b expected=%b", t, tx_bit, e);
                end
            end
        end
    end

    task automatic report;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog: actual=hung expected=completion");
            report();
        end
    end

    initial begin
        idle(3); @(negedge clk); rst_n = 1; idle(2);
        // R1: nothing held, idle ones
        exp_ones(MFB, "R1"); run_mf(1);
        // R2, R3: one-multiframe message, repeated without a gap
        wr_byte(8'hA5); wr_byte(8'h3C); do_commit(2);
        for (int i = 0; i < 3; i++) begin exp_byte(8'hA5, "R2"); exp_byte(8'h3C, "R3"); end
        run_mf(3);
        // R3: short message idles at 1 until the boundary
        wr_byte(8'h81); do_commit(1);
        for (int i = 0; i < 2; i++) begin exp_byte(8'h81, "R3"); exp_ones(8, "R3"); end
        run_mf(2);
        // R4, R5: message spanning two multiframes, new commit mid-message
        wr_byte(8'h11); wr_byte(8'h22); wr_byte(8'h33); wr_byte(8'h44); do_commit(4);
        exp_byte(8'h11, "R5"); exp_byte(8'h22, "R5"); run_mf(1);
        wr_byte(8'hF0); wr_byte(8'h0F); do_commit(2);
        exp_byte(8'h33, "R4"); exp_byte(8'h44, "R4");
        for (int i = 0; i < 2; i++) begin exp_byte(8'hF0, "R5"); exp_byte(8'h0F, "R5"); end
        run_mf(3);
        // R4: three-byte message restarts only after it ends
        wr_byte(8'hAA); wr_byte(8'hBB); wr_byte(8'hCC); do_commit(3);
        for (int i = 0; i < 2; i++) begin
            exp_byte(8'hAA, "R4"); exp_byte(8'hBB, "R4"); exp_byte(8'hCC, "R4"); exp_ones(8, "R4");
        end
        run_mf(4);
        // R6: out-of-range commit lengths change nothing
        do_commit(0); do_commit(DEPTH + 1);
        exp_byte(8'hAA, "R6"); exp_byte(8'hBB, "R6"); exp_byte(8'hCC, "R6"); exp_ones(8, "R6");
        run_mf(2);
        // R7: DEPTH+1 writes, the extra one is dropped; full-length message
        for (int i = 0; i <= DEPTH; i++) wr_byte(8'(i + 1));
        do_commit(DEPTH);
        for (int i = 0; i < DEPTH; i++) exp_byte(8'(i + 1), "R7");
        run_mf(DEPTH * 8 / MFB);
        // R10: switch to FIFO mode, old message discarded
        @(negedge clk); repeat_en = 0; idle(2);
        exp_ones(8, "R10"); run_plain(8);
        // R8: FIFO order, no alignment, commit and mf_start ignored
        wr_byte(8'h12); wr_byte(8'h34);
        exp_byte(8'h12, "R8"); exp_byte(8'h34, "R8"); exp_ones(8, "R8");
        run_plain(24);
        // R9: one write beyond capacity is dropped
        for (int i = 0; i <= 2 * DEPTH; i++) wr_byte(8'(i));
        for (int i = 0; i < 2 * DEPTH; i++) exp_byte(8'(i), "R9");
        exp_ones(8, "R9");
        run_plain(2 * DEPTH * 8 + 8);
        // R10: back to repeat mode, nothing left to play
        wr_byte(8'h5A);
        @(negedge clk); repeat_en = 1; idle(2);
        exp_ones(MFB, "R10"); run_mf(1);
        idle(4);
        n_run++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R2 missing requests: actual=%0d left expected=0", exp_q.size());
        end
        done = 1;
        report();
    end
endmodule